// File: doc/BRIEF.md
# Latched-Address SRAM Cycle Controller

This block sits between a synchronous host and an asynchronous CMOS static RAM. The RAM captures its address on the falling edge of its active-low chip enable. Every access is therefore a full strobe cycle: drive the address, pull the enable low, hold it low long enough, then return it high for a recovery interval before the next access can start. The host sees a request/acknowledge interface. It presents an address, a read/write flag and write data while `reqReady` is high. It later receives a one-cycle `ack`, and for reads the returned data comes with it.

All waits are counted in clock cycles. Each one is the ceiling of a nanosecond minimum divided by the clock period `CLK_NS`. The minimums are picked from one of three speed grades by `GRADE`. With the defaults (8 ns clock, fastest grade) the counts are as follows:

| Quantity | Cycles |
|---|---|
| Enable-low time, read | 16 |
| Enable-low time, write | 15 |
| Recovery length | 7 |
| Minimum fall-to-fall cycle | 22 |

On the memory side the data bus is split into an output, an output-enable and an input, ready to feed a bidirectional pad.

Top module: `sram_latch_ctl`

## Requirements
- R1: In reset, and at once when reset is applied in the middle of an access, the enable and write strobes are high, the data output-enable and `ack` are low, and `reqReady` is high.
- R2: A request is taken only on a clock edge where `reqReady` is high. `reqReady` is low from the accepting edge until the recovery interval has ended. A request presented while `reqReady` is low produces no enable cycle and no memory write.
- R3: The address is loaded on the accepting edge, at least one cycle before the enable falls. It stays unchanged for the whole time the enable is low.
- R4: A read holds the enable low for max(ceil(enable-low minimum), ceil(access time)+1) cycles, which is 16 at the defaults. The write strobe stays high throughout the read.
- R5: Read data is sampled from the bus on the edge where the enable rises. `rdData` holds that value while `ack` is high. `ack` is high for exactly one cycle, and it is first seen 18 cycles after the accepting edge at the defaults.
- R6: A write drops the enable and write strobes on the same edge and raises them together. They stay low for the largest of the rounded enable-low, write-pulse, data-setup and enable-to-write-rise minimums, which is 15 cycles at the defaults. The data output-enable rises with the write strobe's fall and drops one cycle after the strobe rises (16 cycles high). The write data is held on the bus for that whole window.
- R7: A write's `ack` is a one-cycle pulse that begins the cycle after both strobes rise. It is first seen 17 cycles after the accepting edge at the defaults.
- R8: The enable stays high between accesses for at least max(ceil(enable-high minimum), ceil(output turn-off time)) cycles, which is 7 at the defaults. Falls are at least ceil(minimum cycle time) cycles apart, which is 22. With requests back to back, the enable is high for 9 cycles. The fall-to-fall distance is then 25 cycles after a read and 24 after a write.
- R9: The data output-enable is never high while a read has the enable low. It is also never high in the turn-off interval that follows a read, so the controller and the memory never drive the bus at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Controller can take a request this cycle |
| ack | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Data returned by the last read |
| memAddr | output | ADDR_W | Memory address bus |
| memCeN | output | 1 | Memory chip enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memDqOut | output | DATA_W | Data driven toward the memory |
| memDqOe | output | 1 | Output-enable for `memDqOut` |
| memDqIn | input | DATA_W | Data returned by the memory |

## Verification
The embedded properties watch the following on every cycle:
- the address does not move across the enable fall or while the enable is low;
- the write strobe only falls together with the enable and stays inside it;
- the output-enable stays within the write strobe plus one cycle;
- the enable-low and enable-high widths never drop under their floors;
- `ack` is a single-cycle pulse.

Only the bench's scenarios can show the rest:
- that read data is sampled late enough to catch the memory's valid window;
- that writes actually land;
- that requests arriving mid-access are dropped;
- that the exact cycle counts and the back-to-back spacing come out as stated.

// File: rtl/sram_latch_ctl_pkg.sv
package sram_latch_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_PRECH
  } ctlState_e;

  // Control-to-datapath strobes, one bit per register event.
  typedef struct packed {
    logic load;
    logic ceFall;
    logic ceRise;
    logic weFall;
    logic weRise;
    logic oeOn;
    logic oeOff;
    logic capture;
    logic ack;
  } ctlStrobe_t;

  localparam int T_SETUP  = 0;
  localparam int T_HOLD   = 1;
  localparam int T_ELOW   = 2;
  localparam int T_EHIGH  = 3;
  localparam int T_CYCLE  = 4;
  localparam int T_ACCESS = 5;
  localparam int T_HIZ    = 6;
  localparam int T_WPULSE = 7;
  localparam int T_DSETUP = 8;
  localparam int T_WLEH   = 9;

  function automatic int pick3(input int grade, input int a, input int b, input int c);
    if (grade == 0) return a;
    if (grade == 1) return b;
    return c;
  endfunction

  // Minimum of each timing quantity in ns; grade 0 is the fastest.
  function automatic int gradeNs(input int grade, input int which);
    case (which)
      T_SETUP:  return pick3(grade, 0, 20, 20);
      T_HOLD:   return pick3(grade, 40, 50, 50);
      T_ELOW:   return pick3(grade, 120, 200, 300);
      T_EHIGH:  return pick3(grade, 50, 90, 120);
      T_CYCLE:  return pick3(grade, 170, 290, 420);
      T_ACCESS: return pick3(grade, 120, 220, 300);
      T_HIZ:    return pick3(grade, 50, 80, 100);
      T_WPULSE: return pick3(grade, 120, 200, 300);
      T_DSETUP: return pick3(grade, 50, 120, 200);
      default:  return pick3(grade, 120, 200, 300);
    endcase
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int nsToCyc(input int grade, input int periodNs, input int which);
    return (gradeNs(grade, which) + periodNs - 1) / periodNs;
  endfunction

endpackage

// File: rtl/sram_latch_ctl_fsm.sv
module sram_latch_ctl_fsm
  import sram_latch_ctl_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int SETUP_C  = 1,
  parameter int RD_LOW_C = 16,
  parameter int WR_LOW_C = 15,
  parameter int RD_PRE_C = 7,
  parameter int WR_PRE_C = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output ctlStrobe_t strb
);

  ctlState_e        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             opWr, opWrNext;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    opWrNext  = opWr;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          opWrNext  = reqWrite;
          stateNext = ST_SETUP;
          cntNext   = CNT_W'(SETUP_C - 1);
        end
      end
      ST_SETUP: begin
        if (cnt == '0) begin
          strb.ceFall = 1'b1;
          strb.weFall = opWr;
          strb.oeOn   = opWr;
          stateNext   = ST_ACTIVE;
          cntNext     = opWr ? CNT_W'(WR_LOW_C - 1) : CNT_W'(RD_LOW_C - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (cnt == '0) begin
          strb.ceRise  = 1'b1;
          strb.weRise  = opWr;
          strb.capture = !opWr;
          strb.ack     = 1'b1;
          stateNext    = ST_PRECH;
          cntNext      = opWr ? CNT_W'(WR_PRE_C - 1) : CNT_W'(RD_PRE_C - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      default: begin
        strb.oeOff = 1'b1;
        if (cnt == '0) stateNext = ST_IDLE;
        else cntNext = cnt - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      opWr  <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      opWr  <= opWrNext;
    end
  end

  assign reqReady = (state == ST_IDLE);

  // R2: once a request is taken the controller is busy next cycle
  assert_busy_after_load_R2: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> !reqReady);

  // R5 / R7: completion is a single pulse
  assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
    strb.ack |=> !strb.ack);

endmodule

// File: rtl/sram_latch_ctl_dp.sv
module sram_latch_ctl_dp
  import sram_latch_ctl_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 4,
  parameter int CNT_W      = 6,
  parameter int MIN_LOW_C  = 15,
  parameter int MIN_HIGH_C = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              ack
);

  always_ff @(posedge clk) begin
    if (rst) begin
      memAddr  <= '0;
      memDqOut <= '0;
      rdData   <= '0;
      memCeN   <= 1'b1;
      memWeN   <= 1'b1;
      memDqOe  <= 1'b0;
      ack      <= 1'b0;
    end else begin
      if (strb.load) begin
        memAddr  <= reqAddr;
        memDqOut <= reqWdata;
      end
      if (strb.ceFall)      memCeN <= 1'b0;
      else if (strb.ceRise) memCeN <= 1'b1;
      if (strb.weFall)      memWeN <= 1'b0;
      else if (strb.weRise) memWeN <= 1'b1;
      if (strb.oeOn)        memDqOe <= 1'b1;
      else if (strb.oeOff)  memDqOe <= 1'b0;
      if (strb.capture)     rdData <= memDqIn;
      ack <= strb.ack;
    end
  end

  // Width counters that feed the checks below
  logic [CNT_W-1:0] lowCnt, highCnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      lowCnt  <= '0;
      highCnt <= '1;
    end else begin
      if (!memCeN) begin
        if (lowCnt != '1) lowCnt <= lowCnt + 1'b1;
      end else begin
        lowCnt <= '0;
      end
      if (memCeN) begin
        if (highCnt != '1) highCnt <= highCnt + 1'b1;
      end else begin
        highCnt <= '0;
      end
    end
  end

  assert_addr_setup_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(memCeN) |-> $stable(memAddr));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  assert_we_with_ce_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(memWeN) |-> $fell(memCeN));

  assert_we_inside_ce_R6: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> !memCeN);

  assert_oe_window_R9: assert property (@(posedge clk) disable iff (rst)
    memDqOe |-> (!memWeN || $past(!memWeN)));

  assert_low_width_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(memCeN) |-> (lowCnt >= CNT_W'(MIN_LOW_C)));

  assert_high_width_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(memCeN) |-> (highCnt >= CNT_W'(MIN_HIGH_C)));

  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

endmodule

// File: rtl/sram_latch_ctl.sv
module sram_latch_ctl
  import sram_latch_ctl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4,
  parameter int CLK_NS = 8,
  parameter int GRADE  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              ack,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int SETUP_C  = imax(1, nsToCyc(GRADE, CLK_NS, T_SETUP));
  localparam int HOLD_C   = nsToCyc(GRADE, CLK_NS, T_HOLD);
  localparam int LOW_C    = nsToCyc(GRADE, CLK_NS, T_ELOW);
  localparam int ACC_C    = nsToCyc(GRADE, CLK_NS, T_ACCESS);
  localparam int CYC_C    = nsToCyc(GRADE, CLK_NS, T_CYCLE);
  localparam int HIGH_C   = imax(nsToCyc(GRADE, CLK_NS, T_EHIGH), nsToCyc(GRADE, CLK_NS, T_HIZ));
  localparam int WSIDE_C  = imax(nsToCyc(GRADE, CLK_NS, T_WPULSE),
                            imax(nsToCyc(GRADE, CLK_NS, T_DSETUP), nsToCyc(GRADE, CLK_NS, T_WLEH)));
  localparam int RD_LOW_C = imax(imax(LOW_C, ACC_C + 1), HOLD_C);
  localparam int WR_LOW_C = imax(imax(LOW_C, WSIDE_C), HOLD_C);
  localparam int RD_PRE_C = imax(imax(HIGH_C, CYC_C - RD_LOW_C), 1);
  localparam int WR_PRE_C = imax(imax(HIGH_C, CYC_C - WR_LOW_C), 1);
  localparam int CNT_W    = $clog2(RD_LOW_C + WR_LOW_C + RD_PRE_C + WR_PRE_C + SETUP_C + 2);

  ctlStrobe_t strb;

  sram_latch_ctl_fsm #(
    .CNT_W(CNT_W), .SETUP_C(SETUP_C), .RD_LOW_C(RD_LOW_C), .WR_LOW_C(WR_LOW_C),
    .RD_PRE_C(RD_PRE_C), .WR_PRE_C(WR_PRE_C)
  ) u_fsm (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strb(strb)
  );

  sram_latch_ctl_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .MIN_LOW_C(LOW_C), .MIN_HIGH_C(HIGH_C)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memDqIn(memDqIn), .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .rdData(rdData), .ack(ack)
  );

endmodule

// File: tb/sram_latch_ctl_bench.sv
module sram_latch_ctl_bench;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              reqReady, ack, memCeN, memWeN, memDqOe;
  logic [DATA_W-1:0] rdData, memDqOut, memDqIn;
  logic [ADDR_W-1:0] memAddr;

  sram_latch_ctl u_sram_latch_ctl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady), .ack(ack),
    .rdData(rdData), .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // Memory model: address latched on enable fall, data valid 16 negedges in
  logic [DATA_W-1:0] mem [1024];
  logic [ADDR_W-1:0] latA = '0;
  int eLowCyc = 0;
  logic modelDrives;
  initial for (int i = 0; i < 1024; i++) mem[i] = DATA_W'(i) ^ 4'h6;
  always @(negedge memCeN) latA = memAddr;
  always @(posedge memWeN) if (!rst) mem[latA] = memDqOut;
  always @(negedge clk) eLowCyc = memCeN ? 0 : eLowCyc + 1;
  assign modelDrives = !memCeN && memWeN;
  assign memDqIn = modelDrives ? ((eLowCyc >= 16) ? mem[latA] : ~mem[latA]) : '0;

  // Strobe monitor
  int lowRun = 0, highRun = 0, wLowRun = 0, oeRun = 0, sinceFall = 0;
  int lastLow = 0, lastHigh = 0, lastCycle = 0, falls = 0;
  int addrBad = 0, contention = 0, oeDataBad = 0;
  logic prevCe = 1'b1;
  logic [ADDR_W-1:0] prevAddr = '0;
  logic [DATA_W-1:0] expWdata = '0;
  always @(negedge clk) begin
    if (!rst) begin
      sinceFall++;
      if (!memCeN) begin
        if (prevCe) begin
          lastHigh = highRun; lastCycle = sinceFall; sinceFall = 0; falls++;
          lowRun = 0; wLowRun = 0; oeRun = 0;
          if (prevAddr != memAddr) addrBad++;
        end
        lowRun++;
        if (memAddr != latA) addrBad++;
      end else begin
        if (!prevCe) begin lastLow = lowRun; highRun = 0; end
        highRun++;
      end
      if (!memWeN) wLowRun++;
      if (memDqOe) begin
        oeRun++;
        if (memDqOut != expWdata) oeDataBad++;
      end
      if (memDqOe && modelDrives) contention++;
    end
    prevCe = memCeN;
    prevAddr = memAddr;
  end

  int nChecks = 0, nErrors = 0;
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic waitReady();
    int n = 0;
    while (!reqReady && n < 200) begin tick(); n++; end
    if (!reqReady) check("R2: ready timeout", 0, 1);
  endtask

  // Issue one request, return negedges until ack is seen
  task automatic doTxn(input logic wr, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, output int lat);
    waitReady();
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    if (wr) expWdata = d;
    lat = 0;
    tick(); lat++;
    reqValid = 1'b0;
    while (!ack && lat < 200) begin tick(); lat++; end
  endtask

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] exp;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b1, 10'h000, 4'h3, 4'h0},
    '{1'b1, 10'h3FF, 4'hC, 4'h0},
    '{1'b1, 10'h155, 4'h5, 4'h0},
    '{1'b0, 10'h000, 4'h0, 4'h3},
    '{1'b0, 10'h3FF, 4'h0, 4'hC},
    '{1'b0, 10'h155, 4'h0, 4'h5},
    '{1'b1, 10'h155, 4'hA, 4'h0},
    '{1'b0, 10'h155, 4'h0, 4'hA},
    '{1'b0, 10'h2AA, 4'h0, 4'hC}
  };

  initial begin
    int lat, f0;
    logic prevWr;
    // R1: reset state
    repeat (3) tick();
    check("R1: ce_n in reset", memCeN, 1);
    check("R1: we_n in reset", memWeN, 1);
    check("R1: oe in reset", memDqOe, 0);
    check("R1: ack in reset", ack, 0);
    check("R1: ready in reset", reqReady, 1);
    rst = 1'b0;
    tick();
    check("R1: ready after reset", reqReady, 1);

    prevWr = 1'b0;
    for (int i = 0; i < 9; i++) begin
      doTxn(VEC[i].wr, VEC[i].addr, VEC[i].data, lat);
      if (VEC[i].wr) begin
        check("R7: write ack latency", lat, 17);
        check("R6: write enable-low width", lastLow, 15);
        check("R6: write strobe low width", wLowRun, 15);
        check("R6: output-enable cycles", oeRun, 16);
        tick();
        check("R7: ack single pulse", ack, 0);
        check("R6: output-enable dropped", memDqOe, 0);
      end else begin
        check("R5: read ack latency", lat, 18);
        check("R5: read data", rdData, VEC[i].exp);
        check("R4: read enable-low width", lastLow, 16);
        check("R4: write strobe stays high", wLowRun, 0);
        check("R9: no output-enable in read", oeRun, 0);
        tick();
        check("R5: ack single pulse", ack, 0);
      end
      if (i > 0) begin
        check("R8: enable-high back to back", lastHigh, 9);
        check("R8: fall-to-fall spacing", lastCycle, prevWr ? 24 : 25);
      end
      prevWr = VEC[i].wr;
    end

    // R2: requests while busy are dropped
    f0 = falls;
    waitReady();
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 10'h001;
    tick(); reqValid = 1'b0;
    repeat (5) tick();
    check("R2: ready low while active", reqReady, 0);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 10'h200; reqWdata = 4'h9;
    tick(); reqValid = 1'b0;
    lat = 0;
    while (!ack && lat < 200) begin tick(); lat++; end
    repeat (2) tick();
    check("R2: ready low in recovery", reqReady, 0);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 10'h200; reqWdata = 4'h9;
    tick(); reqValid = 1'b0;
    waitReady();
    check("R2: one enable cycle only", falls - f0, 1);
    doTxn(1'b0, 10'h200, 4'h0, lat);
    check("R2: ignored write left memory", rdData, 6);

    // R1: reset in the middle of an access
    waitReady();
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 10'h0F0; reqWdata = 4'h1;
    expWdata = 4'h1;
    tick(); reqValid = 1'b0;
    repeat (5) tick();
    rst = 1'b1;
    tick();
    check("R1: ce_n after mid reset", memCeN, 1);
    check("R1: we_n after mid reset", memWeN, 1);
    check("R1: oe after mid reset", memDqOe, 0);
    check("R1: ready after mid reset", reqReady, 1);
    tick();
    rst = 1'b0;
    doTxn(1'b1, 10'h0F1, 4'h7, lat);
    doTxn(1'b0, 10'h0F1, 4'h0, lat);
    check("R5: read after mid reset", rdData, 7);

    check("R3: address stable across enable low", addrBad, 0);
    check("R9: bus contention cycles", contention, 0);
    check("R6: write data held on bus", oeDataBad, 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nErrors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule